// File: doc/BRIEF.md
# Three-Phase Complementary Output Stage with Dead-Time Insertion

This block sits between a three-phase PWM generator and the gate-drive pins of an inverter bridge. For each of three phases it takes one raw level and turns it into a complementary pair: a high-side (positive) output and a low-side (negative) output. Each time a raw phase changes level, the output that was on is switched off at once. The output that is about to turn on is held off for a programmable number of dead-time ticks. This guard interval keeps the two transistors of a leg from conducting at the same time.

Each phase has its own 8-bit countdown. All three counters load from one shared reload value. The tick that advances the counters is chosen from two strobe sources, either at full rate or at half rate. Separate polarity selects for the positive and negative sides set which pin level means "active". Software can also bypass dead-time generation and set the pair levels directly. In that mode a lock function blocks any pair from driving both of its outputs active, and a sticky flag records every attempt to do so. A low-active cutoff input drops all six output enables with no clock involved, so the pins float for as long as it is held low.

Top module: `dts_top`

## Requirements
- R1: While reset is asserted and afterwards, until the first selected tick arrives, every output of every pair is inactive, all six output enables are 1 and the fault flag is 0. With the raw phases low, the negative outputs become active on the clock that consumes that first tick.
- R2: With dead time enabled and a reload value p from 1 to 255, a change of raw phase i is registered on the next clock. From that clock on, the output that was active is inactive. The output that becomes active stays inactive until p selected ticks later. With a tick on every clock this gives p clocks in which both outputs of the pair are inactive.
- R3: When dead time is disabled (dt_enable = 0), or the reload value is 0, the pair follows its raw phase one clock after the change, with no interval in which both outputs are inactive.
- R4: If a raw phase changes again before its countdown has expired, the countdown restarts from the full reload value. A raw pulse shorter than the dead time therefore never makes either output of that pair active.
- R5: tick_sel selects the tick source: 0 = every strobe on src_a_en, 1 = every strobe on src_b_en, 2 = the 2nd, 4th, 6th, … strobe on src_a_en counted since reset, 3 = the same on src_b_en. Countdowns advance only on the selected ticks.
- R6: pos_act_high = 1 drives an active positive output as pin level 1 and an inactive one as 0. pos_act_high = 0 inverts this. neg_act_high does the same for the negative pins, independently.
- R7: With direct_en = 1, bit i of direct_pos and bit i of direct_neg set the requested activity of pair i in the same cycle, without a clock edge and bypassing the dead-time logic.
- R8: With pair_lock_en = 1, a pair whose positive and negative outputs are both requested active drives both inactive, while the other pairs are unaffected. With pair_lock_en = 0 the request passes unchanged.
- R9: overlap_fault is set on the clock after any pair has both outputs requested active, whether or not the lock blocks them. It stays set until a clock on which fault_clr = 1 and no pair is in conflict. If a conflict and a clear occur together, the conflict wins.
- R10: With cut_enable = 1 and cut_n = 0, all six output enables are 0 at once, without waiting for a clock, for as long as cut_n stays low. With cut_enable = 0, cut_n has no effect on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_en | input | 1 | Strobe from tick source A |
| src_b_en | input | 1 | Strobe from tick source B |
| tick_sel | input | 2 | Tick source select (see R5) |
| dt_enable | input | 1 | 1 = insert dead time |
| dt_reload | input | 8 | Shared dead-time reload value, in ticks |
| phase_raw | input | 3 | Raw phase levels, bit i = phase i |
| pos_act_high | input | 1 | Active level of the positive pins |
| neg_act_high | input | 1 | Active level of the negative pins |
| pair_lock_en | input | 1 | Block pairs that have both sides requested |
| direct_en | input | 1 | Use direct levels instead of the dead-time logic |
| direct_pos | input | 3 | Direct positive-side requests |
| direct_neg | input | 3 | Direct negative-side requests |
| fault_clr | input | 1 | Clear request for the overlap flag |
| cut_enable | input | 1 | Arms the forced cutoff |
| cut_n | input | 1 | Asynchronous low-active cutoff |
| pos_pin | output | 3 | Positive-side pin values |
| neg_pin | output | 3 | Negative-side pin values |
| pos_oe | output | 3 | Positive-side output enables |
| neg_oe | output | 3 | Negative-side output enables |
| overlap_fault | output | 1 | Sticky flag for a pair with both sides requested |

## Verification
The bench times the gap after each edge clock by clock. A design that drops one count, or lets the tick on the edge clock advance the counter, would turn on one cycle early. A pulse shorter than the dead time catches a design that keeps counting instead of restarting, because that design would briefly light the other side. Half-rate ticks are checked against the strobe count since reset, which exposes a divider that fires on odd strobes. The fault flag is driven with a clear that coincides with a conflict, so a design that gives the clear priority would drop a live fault. The cutoff enables are sampled within a nanosecond of cut_n falling, so a registered cutoff path would show up.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    TS_SRC_A      = 2'd0,
    TS_SRC_B      = 2'd1,
    TS_SRC_A_HALF = 2'd2,
    TS_SRC_B_HALF = 2'd3
  } tick_sel_e;
endpackage

// File: rtl/dts_tick_gen.sv
module dts_tick_gen
  import dts_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src_a,
  input  logic      src_b,
  input  tick_sel_e sel,
  output logic      tick
);
  logic half_a_q, half_a_d;
  logic half_b_q, half_b_d;

  // half-rate phase bits toggle on every strobe of their own source
  always_comb begin
    half_a_d = ~half_a_q;
    half_b_d = ~half_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_a_q <= 1'b0;
      half_b_q <= 1'b0;
    end else begin
      if (src_a) half_a_q <= half_a_d;
      if (src_b) half_b_q <= half_b_d;
    end
  end

  always_comb begin
    case (sel)
      TS_SRC_A:      tick = src_a;
      TS_SRC_B:      tick = src_b;
      TS_SRC_A_HALF: tick = src_a & half_a_q;
      TS_SRC_B_HALF: tick = src_b & half_b_q;
      default:       tick = 1'b0;
    endcase
  end

  // R5: a tick only ever comes from a strobe of the selected source
  a_r5_tick_from_selected: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (((sel == TS_SRC_A) || (sel == TS_SRC_A_HALF)) ? src_a : src_b));

  // R5: two half-rate ticks never come from consecutive strobes
  a_r5_half_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == TS_SRC_A_HALF && tick) |=> !(sel == TS_SRC_A_HALF && tick && $past(src_a)));
endmodule

// File: rtl/dts_phase_timer.sv
module dts_phase_timer #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            raw,
  input  logic            dt_en,
  input  logic [DT_W-1:0] reload,
  output logic            pos_req,
  output logic            neg_req
);
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic            raw_q, raw_d;
  logic            busy_q, busy_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            level_change;
  logic            reload_zero;

  always_comb begin
    level_change = raw ^ raw_q;
    reload_zero  = (reload == '0);
    raw_d        = raw_q;
    busy_d       = busy_q;
    cnt_d        = cnt_q;
    if (level_change) begin
      // a new edge always restarts the guard interval, ticks ignored
      raw_d  = raw;
      cnt_d  = reload;
      busy_d = dt_en & ~reload_zero;
    end else if (!dt_en) begin
      busy_d = 1'b0;
    end else if (busy_q && tick) begin
      if (cnt_q <= CNT_ONE) busy_d = 1'b0;
      else                  cnt_d  = cnt_q - CNT_ONE;
    end
  end

  // reset starts in the blanked state until the first tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      raw_q  <= raw_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pos_req = raw_q & ~busy_q;
  assign neg_req = ~raw_q & ~busy_q;

  // R2: the generated pair is never active on both sides
  a_r2_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_req && neg_req));

  // R4: with a nonzero dead time, every raw change blanks the pair next clock
  a_r4_edge_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_en && reload != '0 && raw != raw_q) |=> (!pos_req && !neg_req));

  // R2: a side only turns on after a clock with both sides off
  a_r2_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pos_req) && $past(dt_en) && $past(reload) != '0) |-> $past(!pos_req && !neg_req));

  // R3: without dead time a high raw level shows on the positive side next clock
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!dt_en && raw) |=> pos_req);
endmodule

// File: rtl/dts_pin_stage.sv
module dts_pin_stage #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] pos_req,
  input  logic [NPH-1:0] neg_req,
  input  logic           direct_en,
  input  logic [NPH-1:0] direct_pos,
  input  logic [NPH-1:0] direct_neg,
  input  logic           lock_en,
  input  logic           pos_act_high,
  input  logic           neg_act_high,
  input  logic           fault_clr,
  input  logic           cut_enable,
  input  logic           cut_n,
  output logic [NPH-1:0] pos_pin,
  output logic [NPH-1:0] neg_pin,
  output logic [NPH-1:0] pos_oe,
  output logic [NPH-1:0] neg_oe,
  output logic           fault
);
  logic [NPH-1:0] pos_want, neg_want, clash;
  logic [NPH-1:0] pos_on, neg_on;
  logic           cut_active;
  logic           fault_q, fault_d;

  always_comb begin
    pos_want   = direct_en ? direct_pos : pos_req;
    neg_want   = direct_en ? direct_neg : neg_req;
    clash      = pos_want & neg_want;
    pos_on     = pos_want & ~(clash & {NPH{lock_en}});
    neg_on     = neg_want & ~(clash & {NPH{lock_en}});
    pos_pin    = ~(pos_on ^ {NPH{pos_act_high}});
    neg_pin    = ~(neg_on ^ {NPH{neg_act_high}});
    cut_active = cut_enable & ~cut_n;
    pos_oe     = {NPH{~cut_active}};
    neg_oe     = {NPH{~cut_active}};
    fault_d    = (fault_q & ~fault_clr) | (|clash);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;

  // R8: with the lock on and active-high pins, no pair shows both pins high
  a_r8_lock_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && pos_act_high && neg_act_high) |-> ((pos_pin & neg_pin) == '0));

  // R9: a direct request for both sides of a pair raises the flag
  a_r9_fault_catch: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_en && ((direct_pos & direct_neg) != '0)) |=> fault_q);

  // R9: the flag only falls when a clear was requested
  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);

  // R10: an armed low cutoff leaves no output enable standing
  a_r10_cut_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_enable && !cut_n) |-> (pos_oe == '0 && neg_oe == '0));
endmodule

// File: rtl/dts_top.sv
module dts_top
  import dts_pkg::*;
#(
  parameter int unsigned NPH  = 3,
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_a_en,
  input  logic            src_b_en,
  input  logic [1:0]      tick_sel,
  input  logic            dt_enable,
  input  logic [DT_W-1:0] dt_reload,
  input  logic [NPH-1:0]  phase_raw,
  input  logic            pos_act_high,
  input  logic            neg_act_high,
  input  logic            pair_lock_en,
  input  logic            direct_en,
  input  logic [NPH-1:0]  direct_pos,
  input  logic [NPH-1:0]  direct_neg,
  input  logic            fault_clr,
  input  logic            cut_enable,
  input  logic            cut_n,
  output logic [NPH-1:0]  pos_pin,
  output logic [NPH-1:0]  neg_pin,
  output logic [NPH-1:0]  pos_oe,
  output logic [NPH-1:0]  neg_oe,
  output logic            overlap_fault
);
  logic           dt_tick;
  logic [NPH-1:0] gen_pos, gen_neg;

  dts_tick_gen u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .src_a (src_a_en),
    .src_b (src_b_en),
    .sel   (tick_sel_e'(tick_sel)),
    .tick  (dt_tick)
  );

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    dts_phase_timer #(.DT_W(DT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (dt_tick),
      .raw     (phase_raw[ph]),
      .dt_en   (dt_enable),
      .reload  (dt_reload),
      .pos_req (gen_pos[ph]),
      .neg_req (gen_neg[ph])
    );
  end

  dts_pin_stage #(.NPH(NPH)) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .pos_req      (gen_pos),
    .neg_req      (gen_neg),
    .direct_en    (direct_en),
    .direct_pos   (direct_pos),
    .direct_neg   (direct_neg),
    .lock_en      (pair_lock_en),
    .pos_act_high (pos_act_high),
    .neg_act_high (neg_act_high),
    .fault_clr    (fault_clr),
    .cut_enable   (cut_enable),
    .cut_n        (cut_n),
    .pos_pin      (pos_pin),
    .neg_pin      (neg_pin),
    .pos_oe       (pos_oe),
    .neg_oe       (neg_oe),
    .fault        (overlap_fault)
  );
endmodule

// File: tb/sim_dts_top.sv
module sim_dts_top;
  logic       clk;
  logic       rst_n;
  logic       src_a_en, src_b_en;
  logic [1:0] tick_sel;
  logic       dt_enable;
  logic [7:0] dt_reload;
  logic [2:0] phase_raw;
  logic       pos_act_high, neg_act_high;
  logic       pair_lock_en;
  logic       direct_en;
  logic [2:0] direct_pos, direct_neg;
  logic       fault_clr;
  logic       cut_enable, cut_n;
  logic [2:0] pos_pin, neg_pin, pos_oe, neg_oe;
  logic       overlap_fault;

  dts_top u0 (
    .clk(clk), .rst_n(rst_n), .src_a_en(src_a_en), .src_b_en(src_b_en),
    .tick_sel(tick_sel), .dt_enable(dt_enable), .dt_reload(dt_reload),
    .phase_raw(phase_raw), .pos_act_high(pos_act_high), .neg_act_high(neg_act_high),
    .pair_lock_en(pair_lock_en), .direct_en(direct_en), .direct_pos(direct_pos),
    .direct_neg(direct_neg), .fault_clr(fault_clr), .cut_enable(cut_enable),
    .cut_n(cut_n), .pos_pin(pos_pin), .neg_pin(neg_pin), .pos_oe(pos_oe),
    .neg_oe(neg_oe), .overlap_fault(overlap_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [2:0] pos;
    logic [2:0] neg;
    logic [2:0] poe;
    logic [2:0] noe;
    logic       fault;
    string      req;
  } item_t;

  item_t      sb_q[$];
  item_t      it;
  int         n_chk;
  int         n_bad;
  logic [2:0] ep, en;
  logic       eoe, ef;

  // monitor: one expected item per cycle, compared away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_chk++;
      if ({pos_pin, neg_pin, pos_oe, neg_oe, overlap_fault} !==
          {it.pos, it.neg, it.poe, it.noe, it.fault}) begin
        n_bad++;
        $display("FAIL %s: pos=%b neg=%b oe=%b/%b fault=%b, expected pos=%b neg=%b oe=%b/%b fault=%b",
                 it.req, pos_pin, neg_pin, pos_oe, neg_oe, overlap_fault,
                 it.pos, it.neg, it.poe, it.noe, it.fault);
      end
    end
  end

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  // push the expectation for this cycle's sample, turning activity into pin levels
  task automatic chk(input string r);
    item_t e;
    e.pos   = pos_act_high ? ep : ~ep;
    e.neg   = neg_act_high ? en : ~en;
    e.poe   = {3{eoe}};
    e.noe   = {3{eoe}};
    e.fault = ef;
    e.req   = r;
    sb_q.push_back(e);
  endtask

  task automatic run(input int n, input string r);
    for (int k = 0; k < n; k++) begin
      nxt();
      chk(r);
    end
  endtask

  task automatic pulse_b(input logic [2:0] p_after, input logic [2:0] n_after);
    nxt();
    src_b_en = 1'b1;
    chk("R5");
    nxt();
    src_b_en = 1'b0;
    ep = p_after;
    en = n_after;
    chk("R5");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; src_a_en = 1'b1; src_b_en = 1'b0; tick_sel = 2'd0;
    dt_enable = 1'b1; dt_reload = 8'd3; phase_raw = 3'b000;
    pos_act_high = 1'b1; neg_act_high = 1'b1; pair_lock_en = 1'b1;
    direct_en = 1'b0; direct_pos = 3'b000; direct_neg = 3'b000;
    fault_clr = 1'b0; cut_enable = 1'b1; cut_n = 1'b1;
    ep = 3'b000; en = 3'b000; eoe = 1'b1; ef = 1'b0;

    // R1: reset state, then release on the first tick
    run(3, "R1");
    nxt(); rst_n = 1'b1; chk("R1");
    nxt(); en = 3'b111; chk("R1");

    // R2: rising edge on phase 0, p = 3, tick every clock
    nxt(); phase_raw = 3'b001; chk("R2");
    nxt(); en = 3'b110; chk("R2");
    run(2, "R2");
    nxt(); ep = 3'b001; chk("R2");
    run(2, "R2");
    // R2: falling edge, positive side drops at once
    nxt(); phase_raw = 3'b000; chk("R2");
    nxt(); ep = 3'b000; chk("R2");
    run(2, "R2");
    nxt(); en = 3'b111; chk("R2");

    // R4: one-clock pulse on phase 1, neither side ever turns on
    nxt(); phase_raw = 3'b010; chk("R4");
    nxt(); phase_raw = 3'b000; en = 3'b101; chk("R4");
    run(3, "R4");
    nxt(); en = 3'b111; chk("R4");

    // R3: dead time disabled, then reload of zero
    nxt(); dt_enable = 1'b0; phase_raw = 3'b100; chk("R3");
    nxt(); ep = 3'b100; en = 3'b011; chk("R3");
    nxt(); dt_enable = 1'b1; dt_reload = 8'd0; phase_raw = 3'b000; chk("R3");
    nxt(); ep = 3'b000; en = 3'b111; chk("R3");
    nxt(); dt_reload = 8'd3; chk("R3");

    // R5: source B selected, source A strobes must not advance the count
    nxt(); tick_sel = 2'd1; phase_raw = 3'b001; chk("R5");
    nxt(); en = 3'b110; chk("R5");
    run(3, "R5");
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b001, 3'b110);
    // R5: half rate on B, strobes 4 and 6 and 8 tick
    nxt(); tick_sel = 2'd3; phase_raw = 3'b000; chk("R5");
    nxt(); ep = 3'b000; chk("R5");
    run(2, "R5");
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b000, 3'b110);
    pulse_b(3'b000, 3'b111);
    nxt(); tick_sel = 2'd0; chk("R5");

    // R6: polarity of each side set independently
    nxt(); pos_act_high = 1'b0; chk("R6");
    nxt(); neg_act_high = 1'b0; chk("R6");
    nxt(); pos_act_high = 1'b1; chk("R6");
    nxt(); neg_act_high = 1'b1; chk("R6");

    // R7 + R8: direct levels, lock off lets the clash through
    nxt(); direct_en = 1'b1; direct_pos = 3'b011; direct_neg = 3'b010; pair_lock_en = 1'b0;
    ep = 3'b011; en = 3'b010; chk("R7");
    nxt(); ef = 1'b1; chk("R9");
    nxt(); pair_lock_en = 1'b1; ep = 3'b001; en = 3'b000; chk("R8");
    // R9: clear together with a live clash keeps the flag
    nxt(); fault_clr = 1'b1; chk("R9");
    nxt(); direct_neg = 3'b000; ep = 3'b011; chk("R9");
    nxt(); fault_clr = 1'b0; ef = 1'b0; chk("R9");
    nxt(); chk("R9");
    // R8 + R9: blocked clash on phase 2 is still reported
    nxt(); direct_pos = 3'b100; direct_neg = 3'b100; ep = 3'b000; en = 3'b000; chk("R8");
    nxt(); ef = 1'b1; chk("R9");
    nxt(); direct_pos = 3'b000; direct_neg = 3'b000; fault_clr = 1'b1; chk("R9");
    nxt(); fault_clr = 1'b0; ef = 1'b0; chk("R9");
    nxt(); direct_en = 1'b0; ep = 3'b000; en = 3'b111; chk("R7");

    // R10: asynchronous cutoff, seen before any clock edge
    nxt(); cut_n = 1'b0; eoe = 1'b0;
    #1;
    n_chk++;
    if ((pos_oe | neg_oe) !== 3'b000) begin
      n_bad++;
      $display("FAIL R10: oe=%b/%b right after cutoff, expected 000/000", pos_oe, neg_oe);
    end
    chk("R10");
    run(2, "R10");
    nxt(); cut_n = 1'b1; eoe = 1'b1; chk("R10");
    nxt(); cut_enable = 1'b0; cut_n = 1'b0; chk("R10");
    nxt(); cut_n = 1'b1; cut_enable = 1'b1; chk("R10");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule